// File: doc/BRIEF.md
# Stall-Free Pipeline Cluster with Exit Buffer

The block is a fixed-latency arithmetic pipeline whose stage registers have no enable and move forward on every clock edge. Each stage adds its own constant to the word it carries. The last stage writes into an exit FIFO. That FIFO is large enough to hold every item that can be inside the cluster at once, so a stall from the consumer never has to reach back into the stages.

Both data edges use valid/ready. A word moves across an edge only in a cycle where valid and ready are both high. A producer may hold valid high while ready is low, and the cluster presents a held word unchanged until it is taken. Upstream back-pressure comes only from bookkeeping inside the cluster: `in_ready` is low while the words already in the FIFO plus the valid words still in the stages fill the FIFO. It never depends combinationally on `out_ready`, so the downstream stall reaches only the FIFO and the input gate.

A parameter selects how the FIFO presents data. In the registered form, a written word becomes visible one cycle after it is written. In the fall-through form, a word written into an empty FIFO appears on the output in the same cycle.

Top module: `sfc_cluster`

## Requirements
- R1: Every accepted word leaves in acceptance order, exactly once. Its value is the input plus LATENCY*(LATENCY+1)/2, modulo 2^WIDTH: stage k (numbered from 1) adds k. With the default LATENCY=4 the total added is 10.
- R2: In an empty cluster with `out_ready` high, a word accepted at clock edge e first shows `out_valid` after edge e+LATENCY in registered mode. In fall-through mode it shows after edge e+LATENCY-1.
- R3: `in_ready` is high exactly when fewer than DEPTH = LATENCY+SLACK words are held in total. Held words are those accepted and not yet delivered. With `out_ready` held low and input always valid, exactly DEPTH words are accepted from an empty cluster.
- R4: No word is lost or overwritten under any pattern of `in_valid` and `out_ready`. The held count never exceeds DEPTH, and it changes each cycle by accepts minus deliveries.
- R5: Empty stage slots (bubbles) take no FIFO space. After a stall, the stored words leave on consecutive cycles with no gaps.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R7: During and straight after reset, `out_valid` is low and `in_ready` is high.
- R8: `in_ready` has no combinational path from `out_ready`. Changing `out_ready` within a cycle leaves `in_ready` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | WIDTH | Offered word |
| in_ready | output | 1 | Cluster can take a word this cycle |
| out_valid | output | 1 | Cluster offers a result |
| out_data | output | WIDTH | Result word |
| out_ready | input | 1 | Consumer takes the result this cycle |

## Verification
A wrong held count shows at the ports at once. `in_ready` then disagrees with the number of words the bench has sent but not yet received, in the very cycle the count goes wrong. If the limit is too loose, a word is overwritten; the bench sees this as a wrong or missing result as soon as that FIFO slot is read. A stage that drops or duplicates a valid bit shows as a missing or extra result after one pipeline latency. A broken read pointer shows as an out-of-order value on the next delivery.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // Constant added by stage number idx (0-based).
  function automatic int unsigned stage_step(int unsigned idx);
    return idx + 1;
  endfunction

  // Sum of all stage constants for a given latency.
  function automatic int unsigned total_gain(int unsigned lat);
    return lat * (lat + 1) / 2;
  endfunction
endpackage

// File: rtl/sfc_stage.sv
module sfc_stage #(
  parameter int WIDTH = 8,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_dat,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_dat
);
  // No enable: the stage always advances.
  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
    out_dat <= in_dat + WIDTH'(STEP);
  end
endmodule

// File: rtl/sfc_exit_fifo.sv
module sfc_exit_fifo #(
  parameter int WIDTH        = 8,
  parameter int DEPTH        = 6,
  parameter bit FALL_THROUGH = 1'b0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic [WIDTH-1:0] wr_dat,
  output logic             rd_vld,
  output logic [WIDTH-1:0] rd_dat,
  input  logic             rd_rdy,
  output logic [CW-1:0]    occ
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             empty, bypass, push, pop;

  assign empty = (occ == '0);

  generate
    if (FALL_THROUGH) begin : g_ft
      assign bypass = empty && wr_vld;
      assign rd_dat = empty ? wr_dat : mem[rp];
    end else begin : g_reg
      assign bypass = 1'b0;
      assign rd_dat = mem[rp];
    end
  endgenerate

  assign rd_vld = !empty || bypass;
  assign pop    = rd_rdy && !empty;
  assign push   = wr_vld && !(bypass && rd_rdy);

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push) wp <= wrap_inc(wp);
      if (pop)  rp <= wrap_inc(rp);
      occ <= occ + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_dat;
  end
endmodule

// File: rtl/sfc_cluster.sv
module sfc_cluster #(
  parameter int WIDTH        = 8,
  parameter int LATENCY      = 4,
  parameter int SLACK        = 2,
  parameter bit FALL_THROUGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready
);
  import sfc_pkg::*;

  localparam int DEPTH = LATENCY + SLACK;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TW    = CW + 1;

  logic             vld [LATENCY+1];
  logic [WIDTH-1:0] dat [LATENCY+1];
  logic [CW-1:0]    fifo_occ;
  logic [TW-1:0]    inflight, total;

  assign vld[0] = in_valid && in_ready;
  assign dat[0] = in_data;

  generate
    for (genvar i = 0; i < LATENCY; i++) begin : g_stage
      sfc_stage #(.WIDTH(WIDTH), .STEP(int'(stage_step(i)))) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_vld(vld[i]), .in_dat(dat[i]),
        .out_vld(vld[i+1]), .out_dat(dat[i+1])
      );
    end
  endgenerate

  always_comb begin
    inflight = '0;
    for (int k = 1; k <= LATENCY; k++) inflight = inflight + TW'(vld[k]);
  end

  assign total    = TW'(fifo_occ) + inflight;
  assign in_ready = (total < TW'(DEPTH));

  sfc_exit_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FALL_THROUGH(FALL_THROUGH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_vld(vld[LATENCY]), .wr_dat(dat[LATENCY]),
    .rd_vld(out_valid), .rd_dat(out_data), .rd_rdy(out_ready),
    .occ(fifo_occ)
  );
endmodule

// File: rtl/sfc_cluster_chk.sv
module sfc_cluster_chk #(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8,
  parameter int CW    = 3,
  parameter int TW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic [CW-1:0]    occ,
  input logic [TW-1:0]    total
);
  logic acc, del;
  assign acc = in_valid && in_ready;
  assign del = out_valid && out_ready;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total <= TW'(DEPTH));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> total == $past(total) + TW'($past(acc)) - TW'($past(del)));

  // R5
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) |-> out_valid);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (total == '0) |-> !out_valid);
endmodule

bind sfc_cluster sfc_cluster_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW), .TW(TW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .occ(fifo_occ), .total(total)
);

// File: tb/sfc_cluster_test.sv
module sfc_cluster_test;
  localparam int W = 8, L = 4, S = 2, D = L + S, GAIN = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [W-1:0] in_data = '0, out_data;
  logic         ft_in_valid = 0, ft_in_ready, ft_out_valid;
  logic [W-1:0] ft_in_data = '0, ft_out_data;

  sfc_cluster #(.WIDTH(W), .LATENCY(L), .SLACK(S), .FALL_THROUGH(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready));

  sfc_cluster #(.WIDTH(W), .LATENCY(L), .SLACK(S), .FALL_THROUGH(1'b1)) uut_ft (
    .clk(clk), .rst_n(rst_n), .in_valid(ft_in_valid), .in_data(ft_in_data), .in_ready(ft_in_ready),
    .out_valid(ft_out_valid), .out_data(ft_out_data), .out_ready(1'b1));

  int checks = 0, fails = 0, sent = 0, got = 0, acc_cnt = 0;
  logic [W-1:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: samples 2 ns after the negedge, well before the next posedge.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      // R3: ready exactly when held words < DEPTH
      chk(in_ready == (q.size() < D), "R3 ready vs held", int'(in_ready), int'(q.size() < D));
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(1'b0, "R1 unexpected output", int'(out_data), -1);
        else begin
          logic [W-1:0] e;
          e = q.pop_front() + W'(GAIN);
          chk(out_data == e, "R1 value/order", int'(out_data), int'(e));
        end
        got++;
      end
      if (in_valid && in_ready) begin
        q.push_back(in_data);
        sent++;
        acc_cnt++;
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n, nft, run;
    bit seen, seen_ft, r0, r1;
    logic [W-1:0] held;

    repeat (3) @(negedge clk);
    #3;
    // R7
    chk(!out_valid, "R7 out_valid in reset", int'(out_valid), 0);
    chk(in_ready, "R7 in_ready in reset", int'(in_ready), 1);
    @(negedge clk) rst_n = 1'b1;
    #3;
    chk(!out_valid && in_ready, "R7 after reset", int'({out_valid, in_ready}), 1);

    // R2: latency in both modes
    @(negedge clk);
    in_valid = 1; in_data = 8'h21; out_ready = 1;
    ft_in_valid = 1; ft_in_data = 8'h33;
    @(negedge clk);
    in_valid = 0; ft_in_valid = 0;
    n = 1; nft = 1; seen = 0; seen_ft = 0;
    for (int c = 0; c < 12; c++) begin
      #3;
      if (!seen && out_valid) begin seen = 1; n = c + 1; end
      if (!seen_ft && ft_out_valid) begin
        seen_ft = 1; nft = c + 1;
        chk(ft_out_data == 8'h33 + W'(GAIN), "R1 fall-through value", int'(ft_out_data), 8'h33 + GAIN);
      end
      @(negedge clk);
    end
    chk(n == L + 1, "R2 registered latency", n, L + 1);
    chk(nft == L, "R2 fall-through latency", nft, L);

    // R1 / R4: random traffic with random stalls
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      in_valid = ($urandom % 3) != 0;
      in_data = W'($urandom);
      out_ready = $urandom % 2;
    end
    @(negedge clk) in_valid = 0; out_ready = 1;
    repeat (20) @(negedge clk);
    chk(sent == got, "R4 no loss", got, sent);
    chk(q.size() == 0, "R1 all delivered", q.size(), 0);

    // R3: capacity with downstream stalled
    out_ready = 0; acc_cnt = 0; in_valid = 1;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      in_data = W'(c * 7 + 1);
    end
    @(negedge clk) in_valid = 0;
    chk(acc_cnt == D, "R3 accepted under stall", acc_cnt, D);
    #3;
    chk(!in_ready, "R3 ready low when full", int'(in_ready), 0);
    // R6: held word stays
    held = out_data;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #3;
      chk(out_valid && out_data == held, "R6 hold under stall", int'(out_data), int'(held));
    end
    // R8: no combinational path from out_ready to in_ready
    @(negedge clk); #1;
    r0 = in_ready; out_ready = 1; #1; r1 = in_ready;
    chk(r0 == r1, "R8 ready independent of out_ready", int'(r1), int'(r0));
    repeat (12) @(negedge clk);
    out_ready = 0; #1;
    r0 = in_ready; out_ready = 1; #1; r1 = in_ready; out_ready = 0;
    chk(r0 == r1 && r0, "R8 ready independent when empty", int'(r1), 1);

    // R5: sparse input during a stall drains with no gaps
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) in_valid = 1; in_data = W'(8'h50 + i);
      @(negedge clk) in_valid = 0;
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    out_ready = 1;
    run = 0;
    for (int c = 0; c < 5; c++) begin
      #3;
      if (c < 3) chk(out_valid, "R5 back-to-back drain", int'(out_valid), 1);
      else       chk(!out_valid, "R5 drain ends", int'(out_valid), 0);
      if (out_valid) run++;
      @(negedge clk);
    end
    chk(run == 3, "R5 run length", run, 3);
    chk(sent == got, "R1 final count", got, sent);
    finish_run();
  end
endmodule